// File: doc/BRIEF.md
# Saturating Accumulator ALU with Scaling Shifter

This block is the arithmetic core of a fixed-point datapath. It holds a 32-bit accumulator and combines it with one other operand on each accepted operation. The second operand is either a 32-bit product word or a 16-bit data word. The data word is widened to 32 bits and shifted left by a scaling shifter. The shift amount comes either from an immediate field or from the low four bits of a temporary register. The result is written back to the accumulator. A sticky overflow flag records arithmetic overflow. An optional saturation mode clamps results to the 32-bit signed limits.

The same block also has three further operations. A multi-cycle normalize operation shifts the accumulator left one place per cycle until its two top bits differ, and counts the shifts in an exponent register. A bit-test operation picks one bit of a data word using the temporary-register index and leaves the accumulator untouched. An accumulator-equals-zero status is provided for conditional branching.

The control is a two-state machine. In `S_IDLE` one operation is accepted per cycle, and every operation except normalize completes in that one cycle. The transition `S_IDLE -> S_NORM` is taken when a normalize operation is accepted. `S_NORM -> S_NORM` repeats while another shift is needed. `S_NORM -> S_IDLE` is taken once the accumulator is normalized or zero. While the machine is in `S_NORM`, `busy` is high and new operations are ignored.

Top module: `salu_core`

## Requirements
- R1: After reset, `acc_out`, `norm_exp`, `ovf_flag`, `test_bit`, `busy` and `done` are all 0, and `acc_eq_zero` is 1.
- R2: Opcodes 1 (load), 2 (add) and 3 (subtract) use the scaled data word as the operand. The scaled word is `op_word` sign-extended to 32 bits, or zero-extended when `sx_off` is 1, then shifted left by `imm_shift`. `done` pulses in the cycle after acceptance.
- R3: Opcodes 4 (load), 5 (add) and 6 (subtract) behave like opcodes 1 to 3, except that the left-shift amount is `treg_lo`.
- R4: Opcodes 7 (load), 8 (add) and 9 (subtract) use `prod_word` unshifted as the operand.
- R5: When `sat_mode` is 1 and an add or subtract overflows, the accumulator becomes 0x7FFFFFFF on positive overflow and 0x80000000 on negative overflow, and `ovf_flag` is set.
- R6: When `sat_mode` is 0 and an add or subtract overflows, the accumulator takes the wrapped 32-bit result and `ovf_flag` is set.
- R7: Opcodes 10 (AND), 11 (OR) and 12 (XOR) combine the accumulator with `op_word` zero-extended to 32 bits. These opcodes never set `ovf_flag`.
- R8: `ovf_flag` stays set until opcode 15 (clear overflow) is accepted. Opcode 15 does not change the accumulator.
- R9: Opcode 13 (normalize) first clears `norm_exp`. In each following cycle where bit 31 equals bit 30 and the accumulator is nonzero, the accumulator shifts left by one and `norm_exp` increments. `busy` is high throughout, and `done` pulses in the cycle after the last step.
- R10: Opcode 14 (bit test) sets `test_bit` to `op_word[15 - treg_lo]`, so index 0 selects the MSB. The accumulator is left unchanged.
- R11: `acc_eq_zero` is 1 exactly when the accumulator is 0.
- R12: While `busy` is high, `op_valid` is ignored and normalization continues unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request, accepted when not busy |
| op_code | input | 4 | Operation code |
| op_word | input | 16 | Data-memory or immediate word |
| prod_word | input | 32 | Shifted product operand |
| imm_shift | input | 4 | Immediate left-shift amount |
| treg_lo | input | 4 | Low bits of temporary register: shift amount or bit index |
| sat_mode | input | 1 | Saturation enable |
| sx_off | input | 1 | Disable sign extension of the data word |
| busy | output | 1 | Normalization in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 32 | Accumulator |
| ovf_flag | output | 1 | Sticky overflow flag |
| acc_eq_zero | output | 1 | Accumulator equals zero |
| test_bit | output | 1 | Result of the last bit test |
| norm_exp | output | 16 | Normalization shift count |

## Verification
On every cycle, the assertions check four things. The overflow flag stays set unless it is explicitly cleared. A saturated overflow lands on one of the two limits. Logical operations and bit tests leave the flag or the accumulator as they were. Each normalize step advances the exponent by one, including while requests arrive during `busy`. The bench scenarios check the actual values. These are the sign- versus zero-extended shifting with both shift sources, wrapped results, the exact exponent for zero, positive, all-ones and single-bit accumulators, and bit-index ordering. No per-cycle property can pin these values down.

// File: rtl/salu_pkg.sv
package salu_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_LDS   = 4'h1,
        OP_ADDS  = 4'h2,
        OP_SUBS  = 4'h3,
        OP_LDT   = 4'h4,
        OP_ADDT  = 4'h5,
        OP_SUBT  = 4'h6,
        OP_LDP   = 4'h7,
        OP_ADDP  = 4'h8,
        OP_SUBP  = 4'h9,
        OP_AND   = 4'hA,
        OP_OR    = 4'hB,
        OP_XOR   = 4'hC,
        OP_NORM  = 4'hD,
        OP_BITT  = 4'hE,
        OP_CLROV = 4'hF
    } op_e;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_NORM = 1'b1
    } state_e;

    typedef enum logic [1:0] {
        BOOL_AND = 2'd0,
        BOOL_OR  = 2'd1,
        BOOL_XOR = 2'd2
    } bool_e;

endpackage

// File: rtl/salu_scaler.sv
module salu_scaler #(
    parameter int WORD_W = 16,
    parameter int ACC_W  = 32,
    parameter int SH_W   = 4
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              sx_off,
    input  logic [SH_W-1:0]   amount,
    output logic [ACC_W-1:0]  scaled
);
    localparam int PAD_W = ACC_W - WORD_W;

    logic [ACC_W-1:0] widened;
    logic             fill;

    // Fill bit for the upper part: the word's sign unless extension is disabled.
    assign fill    = word_in[WORD_W-1] & ~sx_off;
    assign widened = {{PAD_W{fill}}, word_in};
    assign scaled  = widened << amount;

endmodule

// File: rtl/salu_addsat.sv
module salu_addsat #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         subtract,
    input  logic         sat_en,
    output logic [W-1:0] result,
    output logic         overflow
);
    localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] b_eff;
    logic [W-1:0] sum;

    assign b_eff    = subtract ? ~b : b;
    assign sum      = a + b_eff + {{(W-1){1'b0}}, subtract};
    // Operands with equal signs that give a result of the other sign.
    assign overflow = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

    always_comb begin
        if (sat_en && overflow) begin
            result = a[W-1] ? NEG_LIMIT : POS_LIMIT;
        end else begin
            result = sum;
        end
    end

endmodule

// File: rtl/salu_bool.sv
module salu_bool
    import salu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  bool_e        sel,
    output logic [W-1:0] result
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (sel)
                BOOL_AND: result[i] = a[i] & b[i];
                BOOL_OR:  result[i] = a[i] | b[i];
                BOOL_XOR: result[i] = a[i] ^ b[i];
                default:  result[i] = a[i];
            endcase
        end
    end

endmodule

// File: rtl/salu_core.sv
module salu_core
    import salu_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int WORD_W = 16,
    parameter int SH_W   = 4,
    parameter int EXP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [WORD_W-1:0] op_word,
    input  logic [ACC_W-1:0]  prod_word,
    input  logic [SH_W-1:0]   imm_shift,
    input  logic [SH_W-1:0]   treg_lo,
    input  logic              sat_mode,
    input  logic              sx_off,
    output logic              busy,
    output logic              done,
    output logic [ACC_W-1:0]  acc_out,
    output logic              ovf_flag,
    output logic              acc_eq_zero,
    output logic              test_bit,
    output logic [EXP_W-1:0]  norm_exp
);
    localparam int            PAD_W     = ACC_W - WORD_W;
    localparam int            IDX_W     = $clog2(WORD_W);
    localparam logic [ACC_W-1:0] POS_LIMIT = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIMIT = {1'b1, {(ACC_W-1){1'b0}}};

    state_e            state_q, state_nx;
    op_e               op;
    logic              accept;
    logic [ACC_W-1:0]  acc_q;
    logic [EXP_W-1:0]  exp_q;
    logic              ovf_q, tc_q, done_q;

    logic [SH_W-1:0]   shift_sel;
    logic [ACC_W-1:0]  scaled;
    logic [ACC_W-1:0]  arith_b;
    logic              is_sub, is_arith, is_prod, is_bool;
    logic [ACC_W-1:0]  sum_res;
    logic              sum_ovf;
    bool_e             bool_sel;
    logic [ACC_W-1:0]  bool_res;
    logic              norm_go;
    logic [IDX_W-1:0]  bit_idx;

    assign op     = op_e'(op_code);
    assign accept = op_valid && (state_q == S_IDLE);

    // ---------------- operand decode ----------------
    always_comb begin
        shift_sel = imm_shift;
        is_sub    = 1'b0;
        is_arith  = 1'b0;
        is_prod   = 1'b0;
        is_bool   = 1'b0;
        bool_sel  = BOOL_AND;
        unique case (op)
            OP_LDS, OP_NOP, OP_NORM, OP_BITT, OP_CLROV: ;
            OP_ADDS: is_arith = 1'b1;
            OP_SUBS: begin is_arith = 1'b1; is_sub = 1'b1; end
            OP_LDT:  shift_sel = treg_lo;
            OP_ADDT: begin shift_sel = treg_lo; is_arith = 1'b1; end
            OP_SUBT: begin shift_sel = treg_lo; is_arith = 1'b1; is_sub = 1'b1; end
            OP_LDP:  is_prod = 1'b1;
            OP_ADDP: begin is_prod = 1'b1; is_arith = 1'b1; end
            OP_SUBP: begin is_prod = 1'b1; is_arith = 1'b1; is_sub = 1'b1; end
            OP_AND:  begin is_bool = 1'b1; bool_sel = BOOL_AND; end
            OP_OR:   begin is_bool = 1'b1; bool_sel = BOOL_OR;  end
            OP_XOR:  begin is_bool = 1'b1; bool_sel = BOOL_XOR; end
        endcase
    end

    salu_scaler #(.WORD_W(WORD_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_scaler (
        .word_in (op_word),
        .sx_off  (sx_off),
        .amount  (shift_sel),
        .scaled  (scaled)
    );

    assign arith_b = is_prod ? prod_word : scaled;

    salu_addsat #(.W(ACC_W)) u_addsat (
        .a        (acc_q),
        .b        (arith_b),
        .subtract (is_sub),
        .sat_en   (sat_mode),
        .result   (sum_res),
        .overflow (sum_ovf)
    );

    salu_bool #(.W(ACC_W)) u_bool (
        .a      (acc_q),
        .b      ({{PAD_W{1'b0}}, op_word}),
        .sel    (bool_sel),
        .result (bool_res)
    );

    assign norm_go = (acc_q[ACC_W-1] == acc_q[ACC_W-2]) && (acc_q != '0);
    assign bit_idx = IDX_W'(WORD_W - 1) - IDX_W'(treg_lo);

    // ---------------- state register ----------------
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE: if (accept && op == OP_NORM) state_nx = S_NORM;
            S_NORM: if (!norm_go)                state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            exp_q  <= '0;
            ovf_q  <= 1'b0;
            tc_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                done_q <= (op != OP_NORM);
                if (is_arith) begin
                    acc_q <= sum_res;
                    if (sum_ovf) ovf_q <= 1'b1;
                end else if (is_bool) begin
                    acc_q <= bool_res;
                end else begin
                    unique case (op)
                        OP_LDS, OP_LDT: acc_q <= scaled;
                        OP_LDP:         acc_q <= prod_word;
                        OP_NORM:        exp_q <= '0;
                        OP_BITT:        tc_q  <= op_word[bit_idx];
                        OP_CLROV:       ovf_q <= 1'b0;
                        default: ;
                    endcase
                end
            end else if (state_q == S_NORM) begin
                if (norm_go) begin
                    acc_q <= acc_q << 1;
                    exp_q <= exp_q + 1'b1;
                end else begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy        = (state_q == S_NORM);
    assign done        = done_q;
    assign acc_out     = acc_q;
    assign ovf_flag    = ovf_q;
    assign acc_eq_zero = (acc_q == '0);
    assign test_bit    = tc_q;
    assign norm_exp    = exp_q;

    // ---------------- assertions ----------------
    p_sticky_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(accept && op == OP_CLROV)) |=> ovf_q)
        else $error("ovf flag dropped without clear");

    p_sat_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_arith && sat_mode && sum_ovf) |=> (acc_q == POS_LIMIT || acc_q == NEG_LIMIT))
        else $error("saturated result off limit");

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_arith && sum_ovf) |=> ovf_q)
        else $error("overflow not flagged");

    p_bool_no_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_bool && !ovf_q) |=> !ovf_q)
        else $error("logical op set overflow");

    p_bitt_keeps_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_BITT) |=> $stable(acc_q))
        else $error("bit test altered accumulator");

    p_norm_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_NORM && norm_go) |=> (exp_q == $past(exp_q) + 1'b1))
        else $error("exponent did not advance");

    p_busy_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid && norm_go) |=> (acc_q == ($past(acc_q) << 1)))
        else $error("request disturbed normalization");

endmodule

// File: tb/salu_core_bench.sv
module salu_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [15:0] op_word = '0;
    logic [31:0] prod_word = '0;
    logic [3:0]  imm_shift = '0;
    logic [3:0]  treg_lo = '0;
    logic        sat_mode = 1'b0;
    logic        sx_off = 1'b0;
    logic        busy, done, ovf_flag, acc_eq_zero, test_bit;
    logic [31:0] acc_out;
    logic [15:0] norm_exp;

    always #4 clk = ~clk;

    salu_core u_salu_core (
        .clk, .rst_n, .op_valid, .op_code, .op_word, .prod_word, .imm_shift,
        .treg_lo, .sat_mode, .sx_off, .busy, .done, .acc_out, .ovf_flag,
        .acc_eq_zero, .test_bit, .norm_exp
    );

    typedef struct {
        logic [31:0] acc;
        logic        ovf;
        logic        tc;
        logic [15:0] ex;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] m_acc = '0;
    logic        m_ovf = 1'b0;
    logic        m_tc = 1'b0;
    logic [15:0] m_exp = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp_v);
        end
    endtask

    // Reference model built from the requirements.
    task automatic model(input logic [3:0] op, input logic [15:0] w, input logic [31:0] p,
                         input logic [3:0] ish, input logic [3:0] tr, input logic sat,
                         input logic sxo);
        logic [31:0] ext, b;
        longint      t;
        ext = sxo ? {16'h0, w} : {{16{w[15]}}, w};
        case (op)
            4'h1: m_acc = ext << ish;
            4'h4: m_acc = ext << tr;
            4'h7: m_acc = p;
            4'h2, 4'h3, 4'h5, 4'h6, 4'h8, 4'h9: begin
                if (op >= 4'h8)      b = p;
                else if (op >= 4'h5) b = ext << tr;
                else                 b = ext << ish;
                if (op == 4'h3 || op == 4'h6 || op == 4'h9)
                    t = longint'($signed(m_acc)) - longint'($signed(b));
                else
                    t = longint'($signed(m_acc)) + longint'($signed(b));
                if (t > 64'sd2147483647 || t < -64'sd2147483648) begin
                    m_ovf = 1'b1;
                    if (sat) m_acc = (t > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
                    else     m_acc = t[31:0];
                end else begin
                    m_acc = t[31:0];
                end
            end
            4'hA: m_acc = m_acc & {16'h0, w};
            4'hB: m_acc = m_acc | {16'h0, w};
            4'hC: m_acc = m_acc ^ {16'h0, w};
            4'hD: begin
                m_exp = '0;
                while (m_acc[31] == m_acc[30] && m_acc != 0) begin
                    m_acc = m_acc << 1;
                    m_exp = m_exp + 1;
                end
            end
            4'hE: m_tc = w[15 - tr];
            4'hF: m_ovf = 1'b0;
            default: ;
        endcase
    endtask

    task automatic push(input string tag);
        item_t it;
        it.acc = m_acc; it.ovf = m_ovf; it.tc = m_tc; it.ex = m_exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // Driver: one operation, wait until the monitor has consumed its result.
    task automatic issue(input logic [3:0] op, input logic [15:0] w, input logic [31:0] p,
                         input logic [3:0] ish, input logic [3:0] tr, input logic sat,
                         input logic sxo, input string tag);
        model(op, w, p, ish, tr, sat, sxo);
        push(tag);
        op_code = op; op_word = w; prod_word = p; imm_shift = ish;
        treg_lo = tr; sat_mode = sat; sx_off = sxo; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: compare every completion against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected done", {31'b0, done}, 32'h0);
            end else begin
                item_t e;
                e = sb.pop_front();
                check(acc_out == e.acc, e.tag, "acc", acc_out, e.acc);
                check(ovf_flag == e.ovf, e.tag, "ovf", {31'b0, ovf_flag}, {31'b0, e.ovf});
                check(test_bit == e.tc, e.tag, "test_bit", {31'b0, test_bit}, {31'b0, e.tc});
                check(norm_exp == e.ex, e.tag, "exp", {16'b0, norm_exp}, {16'b0, e.ex});
                check(acc_eq_zero == (e.acc == 0), "R11", "zero",
                      {31'b0, acc_eq_zero}, {31'b0, (e.acc == 0)});
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", sb.size());
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(acc_out == 0 && norm_exp == 0 && !ovf_flag && !test_bit && !busy && !done,
              "R1", "reset outputs", acc_out, 32'h0);
        check(acc_eq_zero == 1'b1, "R1", "reset zero flag", {31'b0, acc_eq_zero}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 scaled word, sign and zero extension
        issue(4'h1, 16'h8001, 0, 4'd4, 0, 0, 0, "R2");
        issue(4'h1, 16'h8001, 0, 4'd4, 0, 0, 1, "R2");
        issue(4'h2, 16'h0010, 0, 4'd0, 0, 0, 0, "R2");
        issue(4'h3, 16'h0020, 0, 4'd1, 0, 0, 0, "R2");
        // R3 register-controlled shift
        issue(4'h4, 16'h7FFF, 0, 0, 4'd15, 1, 0, "R3");
        issue(4'h5, 16'h7FFF, 0, 0, 4'd15, 1, 0, "R3");
        // R5 positive saturation
        issue(4'h5, 16'h7FFF, 0, 0, 4'd15, 1, 0, "R5");
        issue(4'h6, 16'hFFFF, 0, 0, 4'd2, 0, 0, "R3");
        issue(4'hF, 0, 0, 0, 0, 0, 0, "R8");
        // R4 product path and R5 negative saturation
        issue(4'h7, 0, 32'h8000_0000, 0, 0, 1, 0, "R4");
        issue(4'h9, 0, 32'h0000_0001, 0, 0, 1, 0, "R5");
        issue(4'hF, 0, 0, 0, 0, 0, 0, "R8");
        issue(4'h7, 0, 32'h7FFF_FFFF, 0, 0, 0, 0, "R4");
        // R6 wrap without saturation
        issue(4'h8, 0, 32'h0000_0001, 0, 0, 0, 0, "R6");
        issue(4'h2, 16'h0001, 0, 0, 0, 0, 0, "R8");
        // R7 logical ops keep the sticky flag, never set it
        issue(4'hA, 16'hFFFF, 0, 0, 0, 0, 0, "R7");
        issue(4'hF, 0, 0, 0, 0, 0, 0, "R8");
        issue(4'h7, 0, 32'hFFFF_00FF, 0, 0, 0, 0, "R4");
        issue(4'hB, 16'h0F00, 0, 0, 0, 0, 0, "R7");
        issue(4'hC, 16'hFFFF, 0, 0, 0, 0, 0, "R7");
        issue(4'h7, 0, 32'h0, 0, 0, 0, 0, "R11");
        // R10 bit test ordering
        issue(4'h7, 0, 32'h1234_5678, 0, 0, 0, 0, "R4");
        issue(4'hE, 16'h8000, 0, 0, 4'd0, 0, 0, "R10");
        issue(4'hE, 16'h8000, 0, 0, 4'd15, 0, 0, "R10");
        issue(4'hE, 16'h0001, 0, 0, 4'd15, 0, 0, "R10");
        // R9 normalization
        issue(4'h7, 0, 32'h0, 0, 0, 0, 0, "R4");
        issue(4'hD, 0, 0, 0, 0, 0, 0, "R9");
        issue(4'h7, 0, 32'h0000_1000, 0, 0, 0, 0, "R4");
        issue(4'hD, 0, 0, 0, 0, 0, 0, "R9");
        issue(4'h7, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R4");
        issue(4'hD, 0, 0, 0, 0, 0, 0, "R9");
        issue(4'h7, 0, 32'h0000_0001, 0, 0, 0, 0, "R4");

        // R12 requests during busy are ignored
        model(4'hD, 0, 0, 0, 0, 0, 0);
        push("R12");
        op_code = 4'hD; op_valid = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R9", "busy during normalize", {31'b0, busy}, 32'h1);
        op_code = 4'h1; op_word = 16'h1234; imm_shift = 4'd0;
        repeat (2) @(negedge clk);
        op_valid = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
        check(!busy, "R12", "busy after normalize", {31'b0, busy}, 32'h0);

        finish_run();
    end

endmodule